// File: doc/BRIEF.md
# Eight-Lane Gated Convolution Processing Element

This block is one processing element for a convolution array. It has eight multiply lanes. Each lane holds one pixel and one weight in its own registers. The pixel registers are linked as a shift chain: a shifted-in pixel enters lane 0, and the pixel that leaves the last lane goes out to the next element in a row. A small configuration unit picks the active lanes for the current kernel shape. Lanes that are not selected have their multiplier operands forced to zero, so they add nothing to the result and their multipliers stay quiet.

Each pass samples the current pixel and weight registers and adds the products of the enabled lanes. A three-stage pipeline carries the pass: the first stage registers the lane products, the second registers the adder tree, and the third holds the accumulator. The accumulator can start from zero or keep adding across passes, so one output pixel can span several passes.

The block has three kernel modes:
- **1x1 mode** uses a single lane. A fully connected layer runs in this mode.
- **3x3 mode** takes two passes: eight taps in the first pass and the ninth tap in the second.
- **Mask mode** uses a programmable lane mask and an explicit last-pass flag. A group of elements uses it to cover larger kernels.

A configuration write is held back until no window is in progress, so a window always uses a single lane selection.

Top module: `conv_pe8`

## Requirements
- R1: When `pix_shift` is high at a clock edge, lane 0 loads `pix_in` and every lane i>0 loads the previous value of lane i-1. `pix_out` always shows the pixel held in lane 7.
- R2: When `wt_we` is high at a clock edge, the weight register of lane `wt_idx` loads `wt_data`. The other weight registers keep their values.
- R3: A lane that is not enabled contributes exactly zero to the partial sum, whatever its pixel and weight hold. Its product register is zero after any pass in which it was disabled. An all-zero mask therefore produces a result of 0.
- R4: A pass (`in_valid` high) adds the signed sum of the enabled products (pixels are 16-bit signed, weights 8-bit signed) to a 32-bit signed accumulator. If `in_clear` is high in the same cycle, the accumulator starts from zero for that pass.
- R5: Mode code 2'b00 (1x1) enables only lane 0. Every pass ends a window. The reserved code 2'b11 behaves exactly like 2'b00.
- R6: Mode code 2'b01 (3x3) runs each window as two passes. The first pass enables lanes 0 to 7 and produces no result. The second pass enables only lane 0 and ends the window.
- R7: Mode code 2'b10 (mask) enables the lanes whose bits are set in `cfg_mask` (bit i selects lane i). A window ends only on a pass with `in_last` high.
- R8: A configuration write (`cfg_we`) is stored as pending. It becomes active only at a clock edge where no window is open and `in_valid` is low, so the earliest it can take effect is the second edge after the write. A write made in the middle of a window does not change the lanes used by that window.
- R9: `psum_valid` is high for one cycle per window-ending pass. It rises after the third clock edge, counting the edge that samples that pass. At that time `psum` holds the accumulated value.
- R10: After reset, `psum_valid`, `psum` and `pix_out` are 0, all pixel and weight registers are 0, and the active mode is 1x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write the pending mode and mask |
| cfg_mode | input | 2 | Kernel mode code: 00 is 1x1, 01 is 3x3, 10 is mask mode, 11 behaves as 1x1 |
| cfg_mask | input | 8 | Lane mask used in mask mode |
| pix_shift | input | 1 | Advance the pixel shift chain |
| pix_in | input | 16 | Pixel entering lane 0 |
| pix_out | output | 16 | Pixel held in lane 7, passed to the neighbour element |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | 3 | Lane whose weight is written |
| wt_data | input | 8 | Weight value |
| in_valid | input | 1 | Start a pass on the current registers |
| in_clear | input | 1 | The pass starts the accumulator from zero |
| in_last | input | 1 | The pass ends the window (mask mode only) |
| psum | output | 32 | Accumulated partial sum |
| psum_valid | output | 1 | `psum` holds a finished window result |

## Verification
Some properties are checked by assertions on every cycle:
- A lane disabled at a pass leaves a zero product.
- The active mode and mask hold steady while a window is open or a pass is being sampled.
- Each 1x1 or 3x3-tail pass enables exactly lane 0.
- Every `psum_valid` is preceded by a pass exactly three edges earlier.

Only the bench scenarios can show that the arithmetic values are right. These cover signed extremes, accumulation across passes, the two-pass 3x3 result, and the zero mask. The scenarios also show that a configuration written mid-window leaves that window's lanes unchanged, and that the shift chain delivers pixels in order.

// File: rtl/cpe_pkg.sv
`timescale 1ns/1ps
package cpe_pkg;
   typedef enum logic [1:0] {
      MODE_1X1  = 2'b00,
      MODE_3X3  = 2'b01,
      MODE_MASK = 2'b10,
      MODE_RSVD = 2'b11
   } pe_mode_e;
endpackage

// File: rtl/cpe_lane.sv
`timescale 1ns/1ps
// One multiply lane: shift-chained pixel register, weight register and a
// gated product register.
module cpe_lane #(
   parameter int PIX_W  = 16,
   parameter int WT_W   = 8,
   localparam int PROD_W = PIX_W + WT_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift_en,
   input  logic signed [PIX_W-1:0]  pix_prev,
   input  logic                     wt_we,
   input  logic signed [WT_W-1:0]   wt_d,
   input  logic                     cap_en,
   input  logic                     lane_en,
   output logic signed [PIX_W-1:0]  pix_q,
   output logic signed [PROD_W-1:0] prod_q
);
   logic signed [WT_W-1:0]   wt_q;
   logic signed [PIX_W-1:0]  op_pix;
   logic signed [WT_W-1:0]   op_wt;
   logic signed [PROD_W-1:0] mul;

   // Operand gating keeps a disabled multiplier's inputs at zero.
   always_comb begin
      op_pix = lane_en ? pix_q : '0;
      op_wt  = lane_en ? wt_q  : '0;
      mul    = op_pix * op_wt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         wt_q   <= '0;
         prod_q <= '0;
      end else begin
         if (shift_en) pix_q  <= pix_prev;
         if (wt_we)    wt_q   <= wt_d;
         if (cap_en)   prod_q <= mul;
      end
   end

   AST_LANE_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !lane_en) |=> (prod_q == '0));  // R3
endmodule

// File: rtl/cpe_sum_tree.sv
`timescale 1ns/1ps
// Registered reduction of all lane products.
module cpe_sum_tree #(
   parameter int LANES  = 8,
   parameter int PROD_W = 24,
   localparam int SUM_W = PROD_W + $clog2(LANES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_v,
   input  logic signed [PROD_W-1:0] prod_i [LANES],
   output logic signed [SUM_W-1:0]  sum_q
);
   logic signed [SUM_W-1:0] sum_c;

   always_comb begin
      sum_c = '0;
      for (int i = 0; i < LANES; i++)
         sum_c = sum_c + {{(SUM_W-PROD_W){prod_i[i][PROD_W-1]}}, prod_i[i]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sum_q <= '0;
      else if (in_v) sum_q <= sum_c;
   end
endmodule

// File: rtl/cpe_cfg.sv
`timescale 1ns/1ps
// Mode/mask configuration with deferred activation and window tracking.
module cpe_cfg
   import cpe_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic [LANES-1:0] cfg_mask,
   input  logic             in_valid,
   input  logic             in_last,
   output logic [LANES-1:0] lane_en,
   output logic             pass_end
);
   logic [1:0]       pend_mode;
   logic [LANES-1:0] pend_mask;
   logic             pend_vld;
   pe_mode_e         act_mode;
   logic [LANES-1:0] act_mask;
   logic             win_open;
   logic             apply;

   assign apply = pend_vld && !win_open && !in_valid;

   always_comb begin
      case (act_mode)
         MODE_3X3: begin
            lane_en  = win_open ? LANES'(1) : LANES'(8'hFF);
            pass_end = win_open;
         end
         MODE_MASK: begin
            lane_en  = act_mask;
            pass_end = in_last;
         end
         default: begin
            lane_en  = LANES'(1);
            pass_end = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mode <= '0;
         pend_mask <= '0;
         pend_vld  <= 1'b0;
         act_mode  <= MODE_1X1;
         act_mask  <= '0;
         win_open  <= 1'b0;
      end else begin
         if (cfg_we) begin
            pend_mode <= cfg_mode;
            pend_mask <= cfg_mask;
            pend_vld  <= 1'b1;
         end else if (apply) begin
            pend_vld  <= 1'b0;
         end
         if (apply) begin
            act_mode <= pe_mode_e'(pend_mode);
            act_mask <= pend_mask;
         end
         if (in_valid) win_open <= !pass_end;
      end
   end

   AST_CFG_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open || in_valid) |=> ($stable(act_mask) && $stable(act_mode)));  // R8
   AST_1X1_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == MODE_1X1 || act_mode == MODE_RSVD) |-> (lane_en == LANES'(1)));  // R5
   AST_3X3_TAIL_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == MODE_3X3 && win_open) |-> (lane_en == LANES'(1)));  // R6
endmodule

// File: rtl/conv_pe8.sv
`timescale 1ns/1ps
// Eight-lane gated convolution processing element.
module conv_pe8 #(
   parameter int LANES = 8,
   parameter int PIX_W = 16,
   parameter int WT_W  = 8,
   parameter int ACC_W = 32,
   localparam int IDX_W  = $clog2(LANES),
   localparam int PROD_W = PIX_W + WT_W,
   localparam int SUM_W  = PROD_W + $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_mode,
   input  logic [LANES-1:0] cfg_mask,
   input  logic             pix_shift,
   input  logic [PIX_W-1:0] pix_in,
   output logic [PIX_W-1:0] pix_out,
   input  logic             wt_we,
   input  logic [IDX_W-1:0] wt_idx,
   input  logic [WT_W-1:0]  wt_data,
   input  logic             in_valid,
   input  logic             in_clear,
   input  logic             in_last,
   output logic [ACC_W-1:0] psum,
   output logic             psum_valid
);
   // Elaboration-time parameter checks
   if (LANES < 8) begin : g_chk_lanes
      $error("conv_pe8: LANES must be at least 8 for the 3x3 mode");
   end
   if (PIX_W < 2 || WT_W < 2) begin : g_chk_widths
      $error("conv_pe8: PIX_W and WT_W must be at least 2");
   end
   if (ACC_W <= SUM_W) begin : g_chk_acc
      $error("conv_pe8: ACC_W must exceed the adder tree width");
   end

   logic [LANES-1:0]         lane_en;
   logic                     pass_end;
   logic signed [PIX_W-1:0]  pix_q  [LANES];
   logic signed [PROD_W-1:0] prod_q [LANES];
   logic signed [SUM_W-1:0]  sum_q;
   logic                     v1, c1, e1, v2, c2, e2;
   logic signed [ACC_W-1:0]  acc_q;

   cpe_cfg #(.LANES(LANES)) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_mask(cfg_mask), .in_valid(in_valid), .in_last(in_last),
      .lane_en(lane_en), .pass_end(pass_end)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic signed [PIX_W-1:0] prev;
      if (i == 0) begin : g_head
         assign prev = pix_in;
      end else begin : g_link
         assign prev = pix_q[i-1];
      end
      cpe_lane #(.PIX_W(PIX_W), .WT_W(WT_W)) lane_i (
         .clk(clk), .rst_n(rst_n), .shift_en(pix_shift), .pix_prev(prev),
         .wt_we(wt_we && (wt_idx == IDX_W'(i))), .wt_d(wt_data),
         .cap_en(in_valid), .lane_en(lane_en[i]),
         .pix_q(pix_q[i]), .prod_q(prod_q[i])
      );
   end

   cpe_sum_tree #(.LANES(LANES), .PROD_W(PROD_W)) tree_i (
      .clk(clk), .rst_n(rst_n), .in_v(v1), .prod_i(prod_q), .sum_q(sum_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; c1 <= 1'b0; e1 <= 1'b0;
         v2 <= 1'b0; c2 <= 1'b0; e2 <= 1'b0;
         acc_q      <= '0;
         psum_valid <= 1'b0;
      end else begin
         v1 <= in_valid; c1 <= in_clear; e1 <= pass_end;
         v2 <= v1;       c2 <= c1;       e2 <= e1;
         if (v2)
            acc_q <= (c2 ? '0 : acc_q) + {{(ACC_W-SUM_W){sum_q[SUM_W-1]}}, sum_q};
         psum_valid <= v2 && e2;
      end
   end

   assign psum    = acc_q;
   assign pix_out = pix_q[LANES-1];

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      psum_valid |-> $past(in_valid, 3));  // R9
endmodule

// File: tb/conv_pe8_tb_top.sv
`timescale 1ns/1ps
module conv_pe8_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0;
   logic [1:0]  cfg_mode = 0;
   logic [7:0]  cfg_mask = 0;
   logic        pix_shift = 0;
   logic [15:0] pix_in = 0;
   logic [15:0] pix_out;
   logic        wt_we = 0;
   logic [2:0]  wt_idx = 0;
   logic [7:0]  wt_data = 0;
   logic        in_valid = 0, in_clear = 0, in_last = 0;
   logic [31:0] psum;
   logic        psum_valid;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   conv_pe8 dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_mask(cfg_mask), .pix_shift(pix_shift), .pix_in(pix_in),
      .pix_out(pix_out), .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
      .in_valid(in_valid), .in_clear(in_clear), .in_last(in_last),
      .psum(psum), .psum_valid(psum_valid)
   );

   typedef struct packed {
      logic [15:0] pix;
      logic [7:0]  wt;
      logic        clr;
      logic [31:0] exp;
   } vec_t;

   // 1x1 passes: lane 0 pixel/weight, clear flag, expected accumulator
   localparam vec_t VEC [5] = '{
      '{16'd100,    8'd3,    1'b1, 32'd300},
      '{16'hFFCE,   8'd4,    1'b0, 32'd100},
      '{16'd7,      8'hFE,   1'b1, 32'hFFFFFFF2},
      '{16'h8000,   8'h80,   1'b1, 32'd4194304},
      '{16'd1000,   8'd127,  1'b0, 32'd4321304}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", req, act, act, exp, exp);
      end
   endtask

   task automatic shift_pix(input logic [15:0] p);
      pix_shift = 1; pix_in = p;
      @(negedge clk);
      pix_shift = 0;
   endtask

   task automatic load_wt(input int idx, input logic [7:0] w);
      wt_we = 1; wt_idx = 3'(idx); wt_data = w;
      @(negedge clk);
      wt_we = 0;
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic [7:0] k);
      cfg_we = 1; cfg_mode = m; cfg_mask = k;
      @(negedge clk);
      cfg_we = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_pass(input logic clr, input logic last,
                          output logic seen, output int lat, output logic [31:0] got);
      seen = 0; lat = 0; got = '0;
      in_valid = 1; in_clear = clr; in_last = last;
      @(negedge clk);
      in_valid = 0; in_clear = 0; in_last = 0;
      for (int k = 1; k <= 5; k++) begin
         if (!seen && psum_valid) begin
            seen = 1; lat = k; got = psum;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic seen;
      int lat;
      logic [31:0] got;

      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 psum_valid", 32'(psum_valid), 0);
      chk("R10 psum", psum, 0);
      chk("R10 pix_out", 32'(pix_out), 0);
      rst_n = 1;
      @(negedge clk);

      // Other lanes hold nonzero data so 1x1 gating is visible (R3)
      for (int i = 0; i < 8; i++) load_wt(i, 8'd5);
      // R1: shift chain order
      for (int i = 0; i < 8; i++) shift_pix(16'(11 + i));
      chk("R1 first pixel reaches lane 7", 32'(pix_out), 11);
      shift_pix(16'd19);
      chk("R1 chain advances", 32'(pix_out), 12);

      // Table walk: 1x1 mode (R5, R4, R2, R3)
      for (int v = 0; v < 5; v++) begin
         shift_pix(VEC[v].pix);
         load_wt(0, VEC[v].wt);
         do_pass(VEC[v].clr, 1'b0, seen, lat, got);
         chk("R5 valid every 1x1 pass", 32'(seen), 1);
         chk("R4 1x1 accumulate", got, VEC[v].exp);
         if (v == 0) chk("R9 latency", 32'(lat), 3);
      end

      // R6: 3x3 two-pass window
      set_cfg(2'b01, 8'h00);
      for (int i = 0; i < 8; i++) load_wt(i, 8'(i + 1));
      for (int i = 1; i <= 8; i++) shift_pix(16'(10 * i));
      do_pass(1'b1, 1'b0, seen, lat, got);
      chk("R6 no result after first 3x3 pass", 32'(seen), 0);
      shift_pix(16'd9);
      load_wt(0, 8'hFD);
      do_pass(1'b0, 1'b0, seen, lat, got);
      chk("R6 valid after second pass", 32'(seen), 1);
      chk("R6 3x3 sum 1200-27", got, 32'd1173);
      chk("R9 3x3 latency", 32'(lat), 3);

      // R7/R8: mask mode, mid-window reconfiguration held back
      set_cfg(2'b10, 8'h0F);
      for (int i = 0; i < 8; i++) load_wt(i, 8'd1);
      for (int i = 0; i < 8; i++) shift_pix(16'd2);
      do_pass(1'b1, 1'b0, seen, lat, got);
      chk("R7 no result without in_last", 32'(seen), 0);
      cfg_we = 1; cfg_mode = 2'b00; cfg_mask = 8'h00;
      @(negedge clk);
      cfg_we = 0;
      do_pass(1'b0, 1'b1, seen, lat, got);
      chk("R8 window keeps mask 0x0F", got, 32'd16);
      do_pass(1'b1, 1'b1, seen, lat, got);
      chk("R8 new 1x1 mode active after window", got, 32'd2);

      // R3: all-zero mask
      set_cfg(2'b10, 8'h00);
      do_pass(1'b1, 1'b1, seen, lat, got);
      chk("R3 zero mask result", got, 32'd0);

      // R4/R7: accumulation over three passes, lanes 0 and 7
      set_cfg(2'b10, 8'h81);
      do_pass(1'b1, 1'b0, seen, lat, got);
      do_pass(1'b0, 1'b0, seen, lat, got);
      do_pass(1'b0, 1'b1, seen, lat, got);
      chk("R4 three-pass accumulation", got, 32'd12);

      // R5: reserved code behaves as 1x1
      set_cfg(2'b11, 8'hFF);
      do_pass(1'b1, 1'b0, seen, lat, got);
      chk("R5 reserved mode valid", 32'(seen), 1);
      chk("R5 reserved mode lane 0 only", got, 32'd2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule